// File: doc/BRIEF.md
# Quarter-word multiply-accumulate unit

This block is the multiply-accumulate datapath of a wide-integer arithmetic engine. Each operation picks one 64-bit quarter of each of two 256-bit operands and multiplies the two quarters into a 128-bit product. The product is moved left by 0, 64, 128 or 192 bits and added into a 256-bit accumulator. The sum wraps at 2^256. An option clears the accumulator before the add. Register-file storage and instruction decode sit outside the block.

Each operation also carries a write-back mode. It can write nothing. It can write the whole new accumulator to the destination. Or it can move the low 128 bits of the new accumulator into the lower or upper half of the destination and then shift the accumulator right by 128 bits. With the third mode, sixteen chained operations build the full 512-bit product of two 256-bit numbers, and no separate add is needed. The accumulator can also be loaded and read directly as a wide special register.

The write-back is registered. Its valid strobe, half enables and data appear one clock after the edge that accepts the operation.

Top module: `qmac_unit`

## Requirements
- R1: After a synchronous active-low reset, `acc_rdata_o`, `wb_data_o` and `wb_wen_o` are zero and `wb_valid_o` is low.
- R2: `sel_a_i` and `sel_b_i` each select quarter k of their operand, meaning bits [64k+63:64k], for k = 0 to 3.
- R3: `shift_i` = k moves the 128-bit product left by 64k bits before the add. Product bits above bit 255 are discarded.
- R4: With `zero_i` = 0, an accepted operation forms a new accumulator value equal to the old accumulator plus the shifted product, modulo 2^256.
- R5: With `zero_i` = 1, the old accumulator is treated as zero, so the new value is the shifted product alone.
- R6: `mode_i` = 1 (full write) raises `wb_valid_o` with `wb_wen_o` = 2'b11 and `wb_data_o` equal to the new accumulator value. The accumulator keeps that value.
- R7: `mode_i` = 2 (shift-out) raises `wb_valid_o` and places bits [127:0] of the new value in one half of `wb_data_o`, with the other half zero. `half_sel_i` = 0 uses bits [127:0] with `wb_wen_o` = 2'b01. `half_sel_i` = 1 uses bits [255:128] with `wb_wen_o` = 2'b10. The accumulator becomes the new value shifted right by 128 bits, with zeros filled in at the top.
- R8: `mode_i` = 0, and the reserved value 3, update the accumulator but keep `wb_valid_o` low and `wb_wen_o` at zero.
- R9: Results appear after the clock edge that accepts an operation. `wb_valid_o` is high for exactly one cycle per accepted writing operation.
- R10: `acc_wr_i` loads `acc_wdata_i` into the accumulator, and `acc_rdata_o` always shows the current accumulator.
- R11: When `acc_wr_i` and `op_valid_i` are high in the same cycle, the direct write wins: the operation is dropped and produces no write-back.
- R12: A cycle with neither an operation nor a direct write leaves the accumulator unchanged.
- R13: The sixteen-operation shift-out sequence over quarters of A and B writes halves that together form the 512-bit product A*B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid_i | input | 1 | Operation request this cycle |
| op_a_i | input | 256 | First wide operand |
| op_b_i | input | 256 | Second wide operand |
| sel_a_i | input | 2 | Quarter index into op_a_i |
| sel_b_i | input | 2 | Quarter index into op_b_i |
| shift_i | input | 2 | Product shift in 64-bit steps |
| zero_i | input | 1 | Clear the accumulator before the add |
| mode_i | input | 2 | 0 none, 1 full write, 2 shift-out, 3 reserved (as 0) |
| half_sel_i | input | 1 | Destination half for shift-out (0 lower, 1 upper) |
| acc_wr_i | input | 1 | Direct accumulator load |
| acc_wdata_i | input | 256 | Direct load value |
| acc_rdata_o | output | 256 | Current accumulator |
| wb_valid_o | output | 1 | Destination write strobe |
| wb_wen_o | output | 2 | Half enables of the destination write (bit 0 lower, bit 1 upper) |
| wb_data_o | output | 256 | Destination write data |

## Verification
The assertions assume that the control inputs are known whenever `op_valid_i` or `acc_wr_i` is high. They make no assumption about how operations and direct loads are ordered: collisions and back-to-back operations are legal, and R11 describes what happens when both requests arrive together.

The stimulus keeps every input at a defined value at all times. It applies changes half a period away from the active edge. It mixes directed cases with random cycles that include collisions, idle cycles and all four mode codes, including the reserved one.

// File: rtl/qmac_pkg.sv
// Shared types of the quarter-word multiply-accumulate unit.
// Assumes nothing beyond a 2-bit mode field at the block edge.
package qmac_pkg;
    typedef enum logic [1:0] {
        WB_NONE  = 2'd0,
        WB_FULL  = 2'd1,
        WB_SHIFT = 2'd2,
        WB_RSVD  = 2'd3
    } wb_mode_e;
endpackage

// File: rtl/qmac_qsel.sv
// Quarter-word selector: returns quarter idx of a wide word.
// Assumes WIDE_W is divisible by four.
module qmac_qsel #(
    parameter int unsigned WIDE_W = 256,
    localparam int unsigned QW = WIDE_W / 4
) (
    input  logic [WIDE_W-1:0] word_i,
    input  logic [1:0]        idx_i,
    output logic [QW-1:0]     quarter_o
);
    logic [QW-1:0] slice [4];

    for (genvar k = 0; k < 4; k++) begin : g_slice
        assign slice[k] = word_i[k*QW +: QW];
    end

    // Pick the indexed slice.
    always_comb quarter_o = slice[idx_i];
endmodule

// File: rtl/qmac_prod_shift.sv
// Multiplies two quarter words and moves the product left by a
// multiple of the quarter width, truncating to the wide width.
// Assumes the operands are already selected.
module qmac_prod_shift #(
    parameter int unsigned WIDE_W = 256,
    localparam int unsigned QW = WIDE_W / 4
) (
    input  logic [QW-1:0]     qa_i,
    input  logic [QW-1:0]     qb_i,
    input  logic [1:0]        shift_i,
    output logic [WIDE_W-1:0] addend_o
);
    logic [2*QW-1:0]   product;
    logic [WIDE_W-1:0] cand [4];

    assign product = qa_i * qb_i;

    for (genvar s = 0; s < 4; s++) begin : g_shift
        assign cand[s] = {{(WIDE_W-2*QW){1'b0}}, product} << (s*QW);
    end

    // Pick the shifted product.
    always_comb addend_o = cand[shift_i];
endmodule

// File: rtl/qmac_acc.sv
// Accumulator register and write-back stage.
// Direct loads win over operations. Write-back outputs are
// registered one cycle after acceptance. Assumes valid control inputs.
module qmac_acc
    import qmac_pkg::*;
#(
    parameter int unsigned WIDE_W = 256,
    localparam int unsigned HALF_W = WIDE_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid_i,
    input  logic              zero_i,
    input  logic [1:0]        mode_i,
    input  logic              half_sel_i,
    input  logic [WIDE_W-1:0] addend_i,
    input  logic              acc_wr_i,
    input  logic [WIDE_W-1:0] acc_wdata_i,
    output logic [WIDE_W-1:0] acc_q,
    output logic              wb_valid_q,
    output logic [1:0]        wb_wen_q,
    output logic [WIDE_W-1:0] wb_data_q
);
    logic              op_fire;
    logic [WIDE_W-1:0] sum;
    wb_mode_e          mode;

    assign mode    = wb_mode_e'(mode_i);
    assign op_fire = op_valid_i && !acc_wr_i;

    // New accumulator value before any shift-out.
    always_comb sum = (zero_i ? '0 : acc_q) + addend_i;

    // Accumulator and write-back registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= '0;
            wb_valid_q <= 1'b0;
            wb_wen_q   <= 2'b00;
            wb_data_q  <= '0;
        end else if (acc_wr_i) begin
            acc_q      <= acc_wdata_i;
            wb_valid_q <= 1'b0;
            wb_wen_q   <= 2'b00;
        end else if (op_fire) begin
            case (mode)
                WB_FULL: begin
                    acc_q      <= sum;
                    wb_valid_q <= 1'b1;
                    wb_wen_q   <= 2'b11;
                    wb_data_q  <= sum;
                end
                WB_SHIFT: begin
                    acc_q      <= sum >> HALF_W;
                    wb_valid_q <= 1'b1;
                    wb_wen_q   <= half_sel_i ? 2'b10 : 2'b01;
                    wb_data_q  <= half_sel_i ? {sum[HALF_W-1:0], {HALF_W{1'b0}}}
                                             : {{HALF_W{1'b0}}, sum[HALF_W-1:0]};
                end
                default: begin
                    acc_q      <= sum;
                    wb_valid_q <= 1'b0;
                    wb_wen_q   <= 2'b00;
                end
            endcase
        end else begin
            wb_valid_q <= 1'b0;
            wb_wen_q   <= 2'b00;
        end
    end

    // R9
    wb_after_write_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_fire && (mode_i == 2'd1 || mode_i == 2'd2)) |=> wb_valid_q);
    // R8
    no_wb_quiet_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_fire && (mode_i == 2'd1 || mode_i == 2'd2)) |=> (!wb_valid_q && wb_wen_q == 2'b00));
    // R10
    direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr_i |=> acc_q == $past(acc_wdata_i));
    // R11
    load_drops_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr_i && op_valid_i) |=> !wb_valid_q);
    // R7
    shift_clears_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_fire && mode_i == 2'd2) |=> acc_q[WIDE_W-1:HALF_W] == '0);
    // R6
    wen_coding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_q |-> (wb_wen_q == 2'b11 || $countones(wb_wen_q) == 1));
    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid_i && !acc_wr_i) |=> acc_q == $past(acc_q));
endmodule

// File: rtl/qmac_unit.sv
// Quarter-word multiply-accumulate unit: selects quarters, multiplies,
// shifts and accumulates, with registered write-back control.
// Assumes the register file and decode sit outside this block.
module qmac_unit #(
    parameter int unsigned WIDE_W = 256,
    localparam int unsigned QW = WIDE_W / 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid_i,
    input  logic [WIDE_W-1:0] op_a_i,
    input  logic [WIDE_W-1:0] op_b_i,
    input  logic [1:0]        sel_a_i,
    input  logic [1:0]        sel_b_i,
    input  logic [1:0]        shift_i,
    input  logic              zero_i,
    input  logic [1:0]        mode_i,
    input  logic              half_sel_i,
    input  logic              acc_wr_i,
    input  logic [WIDE_W-1:0] acc_wdata_i,
    output logic [WIDE_W-1:0] acc_rdata_o,
    output logic              wb_valid_o,
    output logic [1:0]        wb_wen_o,
    output logic [WIDE_W-1:0] wb_data_o
);
    logic [QW-1:0]     qa, qb;
    logic [WIDE_W-1:0] addend;

    qmac_qsel #(.WIDE_W(WIDE_W)) u_sel_a (.word_i(op_a_i), .idx_i(sel_a_i), .quarter_o(qa));
    qmac_qsel #(.WIDE_W(WIDE_W)) u_sel_b (.word_i(op_b_i), .idx_i(sel_b_i), .quarter_o(qb));

    qmac_prod_shift #(.WIDE_W(WIDE_W)) u_prod (
        .qa_i(qa), .qb_i(qb), .shift_i(shift_i), .addend_o(addend)
    );

    qmac_acc #(.WIDE_W(WIDE_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .zero_i(zero_i),
        .mode_i(mode_i), .half_sel_i(half_sel_i), .addend_i(addend),
        .acc_wr_i(acc_wr_i), .acc_wdata_i(acc_wdata_i), .acc_q(acc_rdata_o),
        .wb_valid_q(wb_valid_o), .wb_wen_q(wb_wen_o), .wb_data_q(wb_data_o)
    );
endmodule

// File: tb/test_qmac_unit.sv
// Bench for qmac_unit: behavioural reference model compared each cycle.
module test_qmac_unit;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid_i = 1'b0;
    logic [255:0] op_a_i = '0, op_b_i = '0, acc_wdata_i = '0;
    logic [1:0]   sel_a_i = '0, sel_b_i = '0, shift_i = '0, mode_i = '0;
    logic         zero_i = 1'b0, half_sel_i = 1'b0, acc_wr_i = 1'b0;
    logic [255:0] acc_rdata_o, wb_data_o;
    logic         wb_valid_o;
    logic [1:0]   wb_wen_o;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    logic [255:0] ref_acc = '0;
    logic         exp_v;
    logic [1:0]   exp_wen;
    logic [255:0] exp_data;
    logic [255:0] dst [4];
    int           chain_dst = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qmac_unit i_qmac_unit (.*);

    function automatic logic [255:0] rnd256();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic check(string req, string what, logic [255:0] act, logic [255:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Advance one clock with the inputs as driven, then compare.
    task automatic tick(string req);
        logic [63:0]  qa, qb;
        logic [127:0] p;
        logic [255:0] sum;
        exp_v = 1'b0;
        exp_wen = 2'b00;
        if (acc_wr_i) begin
            ref_acc = acc_wdata_i;
        end else if (op_valid_i) begin
            qa  = op_a_i[64*sel_a_i +: 64];
            qb  = op_b_i[64*sel_b_i +: 64];
            p   = 128'(qa) * 128'(qb);
            sum = (zero_i ? 256'd0 : ref_acc) + (256'(p) << (64 * int'(shift_i)));
            if (mode_i == 2'd1) begin
                exp_v = 1'b1; exp_wen = 2'b11; exp_data = sum; ref_acc = sum;
            end else if (mode_i == 2'd2) begin
                exp_v = 1'b1;
                exp_wen = half_sel_i ? 2'b10 : 2'b01;
                exp_data = half_sel_i ? {sum[127:0], 128'd0} : {128'd0, sum[127:0]};
                ref_acc = sum >> 128;
            end else begin
                ref_acc = sum;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(req, "acc", acc_rdata_o, ref_acc);
        check(req, "wb_valid", 256'(wb_valid_o), 256'(exp_v));
        check(req, "wb_wen", 256'(wb_wen_o), 256'(exp_wen));
        if (exp_v) check(req, "wb_data", wb_data_o, exp_data);
        if (wb_valid_o) begin
            if (wb_wen_o[0]) dst[chain_dst][127:0]   = wb_data_o[127:0];
            if (wb_wen_o[1]) dst[chain_dst][255:128] = wb_data_o[255:128];
        end
        op_valid_i = 1'b0;
        acc_wr_i = 1'b0;
    endtask

    task automatic op(logic [255:0] a, logic [255:0] b, logic [1:0] sa, logic [1:0] sb,
                      logic [1:0] sh, logic z, logic [1:0] m, logic hs, string req);
        op_a_i = a; op_b_i = b; sel_a_i = sa; sel_b_i = sb; shift_i = sh;
        zero_i = z; mode_i = m; half_sel_i = hs; op_valid_i = 1'b1;
        tick(req);
    endtask

    task automatic load(logic [255:0] v, string req);
        acc_wdata_i = v; acc_wr_i = 1'b1;
        tick(req);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [255:0] a, b;
        logic [511:0] full;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "acc", acc_rdata_o, '0);
        check("R1", "wb_valid", 256'(wb_valid_o), '0);
        check("R1", "wb_wen", 256'(wb_wen_o), '0);
        check("R1", "wb_data", wb_data_o, '0);
        rst_n = 1'b1;

        // R2 each quarter index on both operands, full write shows product
        a = rnd256(); b = rnd256();
        for (int k = 0; k < 4; k++) begin
            op(a, b, 2'(k), 2'(3-k), 2'd0, 1'b1, 2'd1, 1'b0, "R2");
            check("R2", "product", wb_data_o,
                  256'(128'(a[64*k +: 64]) * 128'(b[64*(3-k) +: 64])));
        end
        // R3 every shift amount, including truncation at 192
        a = '1; b = '1;
        for (int s = 0; s < 4; s++) op(a, b, 2'd3, 2'd3, 2'(s), 1'b1, 2'd1, 1'b0, "R3");
        check("R3", "top shift truncates", acc_rdata_o, {64'h1, 192'd0});
        // R4 accumulate with wrap modulo 2^256
        load({256{1'b1}}, "R10");
        op(256'd1, 256'd1, 2'd0, 2'd0, 2'd0, 1'b0, 2'd1, 1'b0, "R4");
        check("R4", "wrap to zero", acc_rdata_o, '0);
        // R5 zeroing ignores old accumulator
        load(rnd256(), "R10");
        op(256'd5, 256'd7, 2'd0, 2'd0, 2'd1, 1'b1, 2'd0, 1'b0, "R5");
        check("R5", "zeroed sum", acc_rdata_o, 256'd35 << 64);
        // R8 mode 0 and reserved mode 3 give no write-back
        op(rnd256(), rnd256(), 2'd1, 2'd2, 2'd0, 1'b0, 2'd0, 1'b0, "R8");
        op(rnd256(), rnd256(), 2'd2, 2'd1, 2'd1, 1'b0, 2'd3, 1'b0, "R8");
        // R6 full write
        op(rnd256(), rnd256(), 2'd0, 2'd1, 2'd2, 1'b0, 2'd1, 1'b0, "R6");
        // R7 shift-out lower then upper
        load(rnd256(), "R10");
        op(rnd256(), rnd256(), 2'd2, 2'd3, 2'd0, 1'b0, 2'd2, 1'b0, "R7");
        op(rnd256(), rnd256(), 2'd1, 2'd0, 2'd1, 1'b0, 2'd2, 1'b1, "R7");
        // R9 back-to-back writing ops then one idle cycle clears the strobe
        op(rnd256(), rnd256(), 2'd0, 2'd0, 2'd0, 1'b0, 2'd1, 1'b0, "R9");
        op(rnd256(), rnd256(), 2'd0, 2'd0, 2'd0, 1'b0, 2'd1, 1'b0, "R9");
        tick("R9");
        // R12 idle cycles hold the accumulator
        tick("R12");
        tick("R12");
        // R11 collision: load wins, op dropped
        op_a_i = rnd256(); op_b_i = rnd256(); mode_i = 2'd1; zero_i = 1'b1;
        op_valid_i = 1'b1; acc_wdata_i = rnd256(); acc_wr_i = 1'b1;
        tick("R11");

        // R13 sixteen-operation 256x256 product
        a = rnd256(); b = rnd256();
        chain_dst = 2;
        op(a, b, 2'd0, 2'd0, 2'd0, 1'b1, 2'd0, 1'b0, "R13");
        op(a, b, 2'd1, 2'd0, 2'd1, 1'b0, 2'd0, 1'b0, "R13");
        op(a, b, 2'd0, 2'd1, 2'd1, 1'b0, 2'd2, 1'b0, "R13");
        op(a, b, 2'd2, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, "R13");
        op(a, b, 2'd1, 2'd1, 2'd0, 1'b0, 2'd0, 1'b0, "R13");
        op(a, b, 2'd0, 2'd2, 2'd0, 1'b0, 2'd0, 1'b0, "R13");
        op(a, b, 2'd3, 2'd0, 2'd1, 1'b0, 2'd0, 1'b0, "R13");
        op(a, b, 2'd2, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, "R13");
        op(a, b, 2'd1, 2'd2, 2'd1, 1'b0, 2'd0, 1'b0, "R13");
        op(a, b, 2'd0, 2'd3, 2'd1, 1'b0, 2'd2, 1'b1, "R13");
        chain_dst = 3;
        op(a, b, 2'd3, 2'd1, 2'd0, 1'b0, 2'd0, 1'b0, "R13");
        op(a, b, 2'd2, 2'd2, 2'd0, 1'b0, 2'd0, 1'b0, "R13");
        op(a, b, 2'd1, 2'd3, 2'd0, 1'b0, 2'd0, 1'b0, "R13");
        op(a, b, 2'd3, 2'd2, 2'd1, 1'b0, 2'd0, 1'b0, "R13");
        op(a, b, 2'd2, 2'd3, 2'd1, 1'b0, 2'd2, 1'b0, "R13");
        op(a, b, 2'd3, 2'd3, 2'd0, 1'b0, 2'd2, 1'b1, "R13");
        full = 512'(a) * 512'(b);
        check("R13", "low product", dst[2], full[255:0]);
        check("R13", "high product", dst[3], full[511:256]);
        chain_dst = 0;

        // R4 random mix of ops, loads, collisions and idles
        for (int i = 0; i < 400; i++) begin
            op_a_i = rnd256(); op_b_i = rnd256();
            sel_a_i = 2'($urandom); sel_b_i = 2'($urandom);
            shift_i = 2'($urandom); mode_i = 2'($urandom);
            zero_i = ($urandom % 6) == 0; half_sel_i = 1'($urandom);
            op_valid_i = ($urandom % 4) != 0;
            acc_wr_i = ($urandom % 8) == 0; acc_wdata_i = rnd256();
            tick("R4");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule